// File: doc/BRIEF.md
# Banked Clock Fan-Out Divider

This block takes a single input clock and fans it out to four banks of five outputs each, twenty outputs in all. Each bank carries either the input clock unchanged or the input clock halved. Its own select line picks which. Every bank that runs halved takes its clock from one shared toggle flop. Because of this, all halved banks are in phase with each other, and their rising edges line up with rising edges of the undivided banks.

A two-bit enable code sets how many banks drive. Bank A always drives while the block is running. The code adds B, then C, then D in a fixed order that is not binary counting. An active-low hold input clears the shared divider and turns off every output at once. Output disable is modelled by two things together: a per-bank output-enable flag brought out as a port, and a high-impedance value on the bank's data bits.

Top module: `banked_clk_fanout`

## Requirements
- R1: Output bit `5*b+i` (i = 0..4) belongs to bank b (b = 0 for A through 3 for D). While bank b is enabled, all five of its bits carry the same waveform.
- R2: With `div_sel[b]` = 1, an enabled bank b follows `clk_in` level for level. It shows exactly one rising edge per input cycle.
- R3: With `div_sel[b]` = 0, an enabled bank b toggles on every rising edge of `clk_in`, giving one rising edge per two input cycles. All halved banks share one phase.
- R4: While `hold_n` is 0, the divider is held at 0 and `bank_oe` is 0000 whatever the enable code. All outputs are then high impedance.
- R5: After `hold_n` rises, halved banks stay low until the next rising edge of `clk_in`. That edge produces their first rising edge.
- R6: While `hold_n` is 1, bank A (`bank_oe[0]`) is always enabled.
- R7: With `hold_n` = 1, `en_code` {bit1,bit0} selects the enabled banks as follows: 00 enables A; 10 enables A and B; 01 enables A, B and C; 11 enables all four. `bank_oe` is thermometer coded from bit 0 upward.
- R8: A disabled bank has its `bank_oe` bit at 0 and high-impedance data, whatever its `div_sel` bit.
- R9: `hold_n` and `en_code` reach `bank_oe` combinationally. A change shows up before any further clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| hold_n | input | 1 | Active-low hold: clears the divider and disables all banks |
| en_code | input | 2 | Bank enable code |
| div_sel | input | 4 | Per-bank select: 1 undivided, 0 halved |
| bank_oe | output | 4 | Per-bank output-enable flags |
| fan_out | output | 20 | Bank outputs, five bits per bank, 'z' when disabled |

## Verification
The enable flags react with no clock at all. The bench therefore checks them a fraction of a nanosecond after it changes `hold_n` or `en_code`, while the clock is still in the same half period. Undivided banks follow the clock level with no register in the path. Halved banks change only on rising input edges, through the one toggle flop. The bench samples every output 1.25 ns after each rising and each falling edge and compares it with a model that counts rising edges since release. The first halved rising edge is looked for in the sample right after the first rising edge that follows release. Divide ratios are confirmed by counting rising transitions over a 40-cycle window: 40 for undivided banks and 20 for halved ones.

// File: rtl/banked_clk_fanout.sv
`timescale 1ns/1ps
module banked_clk_fanout #(
  parameter int OUTS_PER_BANK = 5
) (
  input  logic                         clk_in,
  input  logic                         hold_n,
  input  logic [1:0]                   en_code,
  input  logic [3:0]                   div_sel,
  output logic [3:0]                   bank_oe,
  output logic [4*OUTS_PER_BANK-1:0]   fan_out
);
  localparam int NUM_BANKS = 4;

  logic       half_q;
  logic [1:0] top_bank;

  assign top_bank = {en_code[0], en_code[1]};

  always_ff @(posedge clk_in or negedge hold_n)
    if (!hold_n) half_q <= 1'b0;
    else         half_q <= ~half_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_clk;
    assign bank_clk   = div_sel[b] ? clk_in : half_q;
    assign bank_oe[b] = hold_n && (top_bank >= 2'(b));
    assign fan_out[b*OUTS_PER_BANK +: OUTS_PER_BANK] =
      bank_oe[b] ? {OUTS_PER_BANK{bank_clk}} : {OUTS_PER_BANK{1'bz}};
  end
endmodule

// File: rtl/banked_clk_fanout_chk.sv
`timescale 1ns/1ps
module banked_clk_fanout_chk #(
  parameter int W = 5
) (
  input logic             clk_in,
  input logic             hold_n,
  input logic [1:0]       en_code,
  input logic [3:0]       div_sel,
  input logic [3:0]       bank_oe,
  input logic [4*W-1:0]   fan_out
);
  assert_reset_oe_off_R4: assert property (@(posedge clk_in)
    !hold_n |-> bank_oe == 4'd0);

  assert_bank_a_on_R6: assert property (@(posedge clk_in) disable iff (!hold_n)
    bank_oe[0]);

  assert_thermometer_R7: assert property (@(posedge clk_in) disable iff (!hold_n)
    (((bank_oe + 4'd1) & bank_oe) == 4'd0) &&
    ($countones(bank_oe) == 32'({en_code[0], en_code[1]}) + 1));

  for (genvar b = 0; b < 4; b++) begin : g_chk
    assert_undivided_high_R2: assert property (@(negedge clk_in) disable iff (!hold_n)
      (bank_oe[b] && div_sel[b]) |-> fan_out[b*W]);

    assert_halved_toggles_R3: assert property (@(negedge clk_in) disable iff (!hold_n)
      ($past(hold_n) && bank_oe[b] && !div_sel[b] && $past(bank_oe[b]) && !$past(div_sel[b]))
      |-> fan_out[b*W] != $past(fan_out[b*W]));
  end
endmodule

bind banked_clk_fanout banked_clk_fanout_chk #(.W(OUTS_PER_BANK)) i_chk (.*);

// File: tb/test_banked_clk_fanout.sv
`timescale 1ns/1ps
module test_banked_clk_fanout;
  logic        clk_in = 1'b0;
  logic        hold_n = 1'b0;
  logic [1:0]  en_code = 2'b00;
  logic [3:0]  div_sel = 4'b0000;
  wire  [3:0]  bank_oe;
  wire  [19:0] fan_out;

  int n_checks = 0;
  int n_fail   = 0;
  int rise_cnt = 0;
  bit finished = 1'b0;

  banked_clk_fanout i_banked_clk_fanout (
    .clk_in(clk_in), .hold_n(hold_n), .en_code(en_code),
    .div_sel(div_sel), .bank_oe(bank_oe), .fan_out(fan_out));

  always #2.5 clk_in = ~clk_in;

  always @(posedge clk_in) rise_cnt <= hold_n ? rise_cnt + 1 : 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_oe(input logic h, input logic [1:0] code);
    int n;
    case (code)
      2'b00: n = 1;
      2'b10: n = 2;
      2'b01: n = 3;
      default: n = 4;
    endcase
    exp_oe = '0;
    for (int b = 0; b < 4; b++) if (h && b < n) exp_oe[b] = 1'b1;
  endfunction

  task automatic compare_sample(input logic lvl);
    logic [3:0] eo;
    eo = exp_oe(hold_n, en_code);
    check(bank_oe == eo, "R7/R8 enable flags", 32'(bank_oe), 32'(eo));
    for (int b = 0; b < 4; b++) begin
      if (eo[b]) begin
        logic e;
        e = div_sel[b] ? lvl : logic'(rise_cnt % 2);
        check(fan_out[b*5 +: 5] == {5{e}}, div_sel[b] ? "R1/R2 bank level" : "R1/R3 bank level",
              32'(fan_out[b*5 +: 5]), 32'({5{e}}));
      end
    end
  endtask

  task automatic run_window(input int cycles);
    int   rises [4];
    logic prev  [4];
    logic [3:0] eo;
    eo = exp_oe(hold_n, en_code);
    @(negedge clk_in); #1.25;
    compare_sample(1'b0);
    for (int b = 0; b < 4; b++) begin rises[b] = 0; prev[b] = fan_out[b*5]; end
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk_in); #1.25;
      compare_sample(1'b1);
      for (int b = 0; b < 4; b++) begin
        if (!prev[b] && fan_out[b*5]) rises[b]++;
        prev[b] = fan_out[b*5];
      end
      @(negedge clk_in); #1.25;
      compare_sample(1'b0);
      for (int b = 0; b < 4; b++) prev[b] = fan_out[b*5];
    end
    for (int b = 0; b < 4; b++)
      if (eo[b]) begin
        int e;
        e = div_sel[b] ? cycles : cycles / 2;
        check(rises[b] == e, div_sel[b] ? "R2 rise count" : "R3 rise count", 32'(rises[b]), 32'(e));
      end
  endtask

  task automatic release_and_check;
    @(negedge clk_in); #0.5;
    hold_n = 1'b1;
    #0.2;
    check(bank_oe == exp_oe(1'b1, en_code), "R9 release enables without clock",
          32'(bank_oe), 32'(exp_oe(1'b1, en_code)));
    #0.55;
    compare_sample(1'b0);
    for (int b = 0; b < 4; b++)
      if (bank_oe[b] && !div_sel[b])
        check(fan_out[b*5] == 1'b0, "R5 halved low before first edge", 32'(fan_out[b*5]), 32'd0);
    @(posedge clk_in); #1.25;
    for (int b = 0; b < 4; b++)
      if (bank_oe[b] && !div_sel[b])
        check(fan_out[b*5] == 1'b1, "R5 first halved rise", 32'(fan_out[b*5]), 32'd1);
    compare_sample(1'b1);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R4: reset state under every enable code
    for (int k = 0; k < 4; k++) begin
      en_code = 2'(k);
      div_sel = 4'(k * 5);
      #3.1;
      check(bank_oe == 4'd0, "R4 all banks off in hold", 32'(bank_oe), 32'd0);
    end
    repeat (3) @(posedge clk_in);
    en_code = 2'b11; div_sel = 4'b0000;
    release_and_check();
    check(bank_oe[0] == 1'b1, "R6 bank A on", 32'(bank_oe[0]), 32'd1);

    // R2/R3: divide patterns with all banks on
    foreach (div_sel[i]) ;
    for (int p = 0; p < 4; p++) begin
      @(posedge clk_in); #0.5;
      case (p)
        0: div_sel = 4'b1111;
        1: div_sel = 4'b0000;
        2: div_sel = 4'b1010;
        default: div_sel = 4'b0101;
      endcase
      run_window(40);
    end

    // R7/R8/R9/R6: every enable code, changed mid-cycle
    div_sel = 4'b0110;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] code;
      code = (k == 0) ? 2'b00 : (k == 1) ? 2'b10 : (k == 2) ? 2'b01 : 2'b11;
      @(posedge clk_in); #0.5;
      en_code = code;
      #0.3;
      check(bank_oe == exp_oe(1'b1, code), "R9 enable code immediate", 32'(bank_oe), 32'(exp_oe(1'b1, code)));
      check(bank_oe[0] == 1'b1, "R6 bank A on for every code", 32'(bank_oe[0]), 32'd1);
      run_window(40);
    end

    // R8: disabled banks stay off when their select changes
    @(posedge clk_in); #0.5;
    en_code = 2'b10;
    div_sel = 4'b1100;
    #0.3;
    check(bank_oe[3:2] == 2'b00, "R8 disabled banks ignore select", 32'(bank_oe[3:2]), 32'd0);
    run_window(20);

    // R4/R9/R5: hold asserted mid-run, then released
    @(posedge clk_in); #0.5;
    hold_n = 1'b0;
    #0.3;
    check(bank_oe == 4'd0, "R4 hold disables at once", 32'(bank_oe), 32'd0);
    repeat (4) @(posedge clk_in);
    #0.4;
    check(bank_oe == 4'd0, "R4 still off in hold", 32'(bank_oe), 32'd0);
    en_code = 2'b01; div_sel = 4'b0010;
    release_and_check();
    run_window(40);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule